// File: doc/BRIEF.md
# Local Interrupt Controller Timer Slice

This block is one core's slice of a local interrupt controller. It holds the state that governs its own countdown timer and the masking of its local interrupt sources. The state is a software-enable flag inside a spurious-vector register, a timer vector-table entry, a set of auxiliary vector-table entries, a clock-divide register, and the initial-count and current-count registers. A simple single-cycle register bus writes these registers and reads them back combinationally.

The timer counts down once per divided clock period. When it reaches its terminal count it raises a level interrupt to the owning core only, carrying the vector from the timer entry. That request stays pending until the core acknowledges it. While the software-enable flag is clear, every table-entry mask reads as set and cannot be cleared, so an expiry in that state delivers nothing. Requests that are already pending stay held. INIT, NMI, SMI and start-up requests pass through to the core in either state.

Top module: `lic_timer`

## Requirements
- R1: After reset the spurious-vector register reads 0x000000FF, so the enable flag (bit 8) is clear. The timer entry reads 0x00010000, the current count reads 0, and irq_pend is low.
- R2: While bit 8 of the spurious-vector register is 0, the mask bit (bit 16) of the timer entry and of every auxiliary entry reads 1. A write that tries to clear it leaves it set, and the vector bits 7:0 are still written (writing 0x00000050 reads back 0x00010050).
- R3: Clearing the enable flag makes every mask read 1 on the next read. The masks stay set after the flag is set again, until software clears them.
- R4: A write to the initial-count register loads the current count with the same value. The current count then drops by one every 2^k clock cycles, where k is bits 2:0 of the divide register (codes 0 to 7, divide by 1 to 128).
- R5: In one-shot mode (timer entry bit 17 = 0) with the mask clear, irq_pend rises N×2^k cycles after the initial-count write of N. irq_vec then equals timer entry bits 7:0, and the current count reads 0 and stays there.
- R6: In periodic mode (bit 17 = 1) the count reloads from the initial value on expiry, and the interrupt recurs every N×2^k cycles.
- R7: An expiry while the timer entry is masked, or while the block is software-disabled, does not raise irq_pend.
- R8: irq_pend stays high until irq_ack is sampled high, also across a software disable. If an expiry and irq_ack fall in the same cycle, the request stays pending.
- R9: Writing 0 to the initial-count register stops the timer. The current count reads 0 and no interrupt follows.
- R10: A request with msg_valid high appears one cycle later as a one-cycle pulse on exactly one of core_init, core_nmi, core_smi or core_sipi, whether or not the block is enabled. msg_type selects the output (0 INIT, 1 NMI, 2 SMI, 3 start-up), and core_sipi_vec carries msg_vec.
- R11: Register word addresses are: 0 spurious vector, 1 timer entry, 2 divide, 3 initial count, 4 current count (read only), and 5 upward for the auxiliary entries. bus_rdata follows bus_addr in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| irq_ack | input | 1 | Core accepts the pending timer interrupt |
| irq_pend | output | 1 | Timer interrupt pending to this core |
| irq_vec | output | 8 | Vector of the pending timer interrupt |
| msg_valid | input | 1 | System message request |
| msg_type | input | 2 | 0 INIT, 1 NMI, 2 SMI, 3 start-up |
| msg_vec | input | 8 | Start-up vector |
| core_init | output | 1 | INIT pulse to the core |
| core_nmi | output | 1 | NMI pulse to the core |
| core_smi | output | 1 | SMI pulse to the core |
| core_sipi | output | 1 | Start-up pulse to the core |
| core_sipi_vec | output | 8 | Start-up vector to the core |

## Verification
Two events can land on the same clock edge: a timer expiry that sets the pending request, and the core's acknowledge that clears it. The bench runs a periodic timer with divide-by-1. It computes the exact edge of the second expiry from the count and holds irq_ack high across that edge alone. It then requires irq_pend to remain high, and to fall only after a later acknowledge. Randomly drawn counts, divide codes and vectors also check the expiry edge to the cycle, by sampling one cycle before it and then on it.

// File: rtl/lic_pkg.sv
package lic_pkg;
   localparam int A_SVR   = 0;
   localparam int A_TMR   = 1;
   localparam int A_DIV   = 2;
   localparam int A_INIT  = 3;
   localparam int A_CUR   = 4;
   localparam int A_AUX0  = 5;
   localparam int BIT_EN   = 8;
   localparam int BIT_MASK = 16;
   localparam int BIT_MODE = 17;
   localparam logic [8:0] SVR_RESET = 9'h0FF;

   typedef enum logic [1:0] {
      MSG_INIT = 2'd0,
      MSG_NMI  = 2'd1,
      MSG_SMI  = 2'd2,
      MSG_SIPI = 2'd3
   } msg_e;
endpackage

// File: rtl/lic_prescaler.sv
module lic_prescaler #(
   parameter int DIV_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic             run,
   input  logic [DIV_W-1:0] code,
   output logic             tick
);
   localparam int PW = (1 << DIV_W) - 1;

   logic [PW-1:0] pcnt_q;
   logic [PW-1:0] limit;

   assign limit = PW'((33'd1 << code) - 33'd1);
   assign tick  = run && !restart && (pcnt_q >= limit);

   always_ff @(posedge clk) begin
      if (!rst_n || restart || !run) begin
         pcnt_q <= '0;
      end else if (pcnt_q >= limit) begin
         pcnt_q <= '0;
      end else begin
         pcnt_q <= pcnt_q + 1'b1;
      end
   end

   AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && code != '0) |=> !tick) else $error("tick too dense"); // R4
endmodule

// File: rtl/lic_countdown.sv
module lic_countdown #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic [CNT_W-1:0] reload_val,
   input  logic             periodic,
   input  logic             tick,
   output logic [CNT_W-1:0] cur,
   output logic             running,
   output logic             expire
);
   logic [CNT_W-1:0] cur_q;
   logic             run_q;

   assign cur     = cur_q;
   assign running = run_q;
   assign expire  = !load && run_q && tick && (cur_q == CNT_W'(1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cur_q <= '0;
         run_q <= 1'b0;
      end else if (load) begin
         cur_q <= load_val;
         run_q <= (load_val != '0);
      end else if (run_q && tick) begin
         if (cur_q == CNT_W'(1)) begin
            if (periodic) begin
               cur_q <= reload_val;
            end else begin
               cur_q <= '0;
               run_q <= 1'b0;
            end
         end else begin
            cur_q <= cur_q - 1'b1;
         end
      end
   end

   AST_ONESHOT_HALT: assert property (@(posedge clk) disable iff (!rst_n)
      (expire && !periodic) |=> (cur == '0 && !running)) else $error("one-shot did not halt"); // R5
   AST_STOP_ON_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (load && load_val == '0) |=> (!running && cur == '0)) else $error("zero load kept running"); // R9
endmodule

// File: rtl/lic_sysmsg.sv
module lic_sysmsg #(
   parameter bit REG_OUT = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        msg_valid,
   input  logic [1:0]  msg_type,
   input  logic [7:0]  msg_vec,
   output logic        core_init,
   output logic        core_nmi,
   output logic        core_smi,
   output logic        core_sipi,
   output logic [7:0]  core_sipi_vec
);
   import lic_pkg::*;

   logic [3:0] dec;
   always_comb begin
      dec = '0;
      if (msg_valid) begin
         case (msg_e'(msg_type))
            MSG_INIT: dec[0] = 1'b1;
            MSG_NMI:  dec[1] = 1'b1;
            MSG_SMI:  dec[2] = 1'b1;
            MSG_SIPI: dec[3] = 1'b1;
            default:  dec = '0;
         endcase
      end
   end

   generate
      if (REG_OUT) begin : g_reg
         logic [3:0] pulse_q;
         logic [7:0] vec_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               pulse_q <= '0;
               vec_q   <= '0;
            end else begin
               pulse_q <= dec;
               if (dec[3]) vec_q <= msg_vec;
            end
         end
         assign {core_sipi, core_smi, core_nmi, core_init} = pulse_q;
         assign core_sipi_vec = vec_q;

         AST_MSG_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
            msg_valid |=> $countones({core_init, core_nmi, core_smi, core_sipi}) == 1)
            else $error("system message lost"); // R10
      end else begin : g_comb
         assign {core_sipi, core_smi, core_nmi, core_init} = dec;
         assign core_sipi_vec = msg_vec;
      end
   endgenerate
endmodule

// File: rtl/lic_timer.sv
module lic_timer #(
   parameter int CNT_W   = 32,
   parameter int DIV_W   = 3,
   parameter int NUM_AUX = 2,
   parameter int ADDR_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic              irq_ack,
   output logic              irq_pend,
   output logic [7:0]        irq_vec,
   input  logic              msg_valid,
   input  logic [1:0]        msg_type,
   input  logic [7:0]        msg_vec,
   output logic              core_init,
   output logic              core_nmi,
   output logic              core_smi,
   output logic              core_sipi,
   output logic [7:0]        core_sipi_vec
);
   import lic_pkg::*;

   localparam int NUM_REGS = A_AUX0 + NUM_AUX;

   generate
      if (CNT_W < 2 || CNT_W > 32) begin : g_bad_cnt
         $error("CNT_W must lie in 2..32");
      end
      if (DIV_W < 1 || DIV_W > 3) begin : g_bad_div
         $error("DIV_W must lie in 1..3");
      end
      if (NUM_AUX < 1 || NUM_REGS > (1 << ADDR_W)) begin : g_bad_map
         $error("register map does not fit ADDR_W");
      end
   endgenerate

   // ---------------- register state ----------------
   logic [8:0]       svr_q;
   logic [7:0]       tmr_vec_q;
   logic             tmr_mask_q;
   logic             tmr_mode_q;
   logic [DIV_W-1:0] div_q;
   logic [CNT_W-1:0] init_q;
   logic [7:0]       aux_vec_q  [NUM_AUX];
   logic             aux_mask_q [NUM_AUX];

   logic sw_en;
   logic tmr_mask_eff;
   assign sw_en        = svr_q[BIT_EN];
   assign tmr_mask_eff = tmr_mask_q | ~sw_en;

   function automatic logic hit(input logic [ADDR_W-1:0] a, input int idx);
      return a == ADDR_W'(idx);
   endfunction

   logic wr_init;
   assign wr_init = bus_wr && hit(bus_addr, A_INIT);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         svr_q      <= SVR_RESET;
         tmr_vec_q  <= '0;
         tmr_mask_q <= 1'b1;
         tmr_mode_q <= 1'b0;
         div_q      <= '0;
         init_q     <= '0;
      end else begin
         if (bus_wr && hit(bus_addr, A_SVR)) svr_q <= bus_wdata[8:0];
         if (bus_wr && hit(bus_addr, A_TMR)) begin
            tmr_vec_q  <= bus_wdata[7:0];
            tmr_mode_q <= bus_wdata[BIT_MODE];
            tmr_mask_q <= bus_wdata[BIT_MASK] | ~sw_en;
         end else if (!sw_en) begin
            tmr_mask_q <= 1'b1;
         end
         if (bus_wr && hit(bus_addr, A_DIV)) div_q <= bus_wdata[DIV_W-1:0];
         if (wr_init) init_q <= bus_wdata[CNT_W-1:0];
      end
   end

   genvar gi;
   generate
      for (gi = 0; gi < NUM_AUX; gi++) begin : g_aux
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               aux_vec_q[gi]  <= '0;
               aux_mask_q[gi] <= 1'b1;
            end else if (bus_wr && hit(bus_addr, A_AUX0 + gi)) begin
               aux_vec_q[gi]  <= bus_wdata[7:0];
               aux_mask_q[gi] <= bus_wdata[BIT_MASK] | ~sw_en;
            end else if (!sw_en) begin
               aux_mask_q[gi] <= 1'b1;
            end
         end

         AST_AUX_MASK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
            !sw_en |=> aux_mask_q[gi]) else $error("aux mask cleared while disabled"); // R2
      end
   endgenerate

   // ---------------- timer datapath ----------------
   logic             tick;
   logic [CNT_W-1:0] cur;
   logic             running;
   logic             expire;

   lic_prescaler #(.DIV_W(DIV_W)) u_pre (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (wr_init),
      .run     (running),
      .code    (div_q),
      .tick    (tick)
   );

   lic_countdown #(.CNT_W(CNT_W)) u_cnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (wr_init),
      .load_val   (bus_wdata[CNT_W-1:0]),
      .reload_val (init_q),
      .periodic   (tmr_mode_q),
      .tick       (tick),
      .cur        (cur),
      .running    (running),
      .expire     (expire)
   );

   // ---------------- pending request ----------------
   logic       pend_q;
   logic [7:0] pvec_q;
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
         pvec_q <= '0;
      end else if (expire && !tmr_mask_eff) begin
         pend_q <= 1'b1;
         pvec_q <= tmr_vec_q;
      end else if (irq_ack) begin
         pend_q <= 1'b0;
      end
   end
   assign irq_pend = pend_q;
   assign irq_vec  = pvec_q;

   // ---------------- system messages ----------------
   lic_sysmsg #(.REG_OUT(1'b1)) u_msg (
      .clk           (clk),
      .rst_n         (rst_n),
      .msg_valid     (msg_valid),
      .msg_type      (msg_type),
      .msg_vec       (msg_vec),
      .core_init     (core_init),
      .core_nmi      (core_nmi),
      .core_smi      (core_smi),
      .core_sipi     (core_sipi),
      .core_sipi_vec (core_sipi_vec)
   );

   // ---------------- read mux ----------------
   always_comb begin
      bus_rdata = '0;
      if (hit(bus_addr, A_SVR)) begin
         bus_rdata = {23'd0, svr_q};
      end else if (hit(bus_addr, A_TMR)) begin
         bus_rdata = {14'd0, tmr_mode_q, tmr_mask_eff, 8'd0, tmr_vec_q};
      end else if (hit(bus_addr, A_DIV)) begin
         bus_rdata = 32'(div_q);
      end else if (hit(bus_addr, A_INIT)) begin
         bus_rdata = 32'(init_q);
      end else if (hit(bus_addr, A_CUR)) begin
         bus_rdata = 32'(cur);
      end else begin
         for (int i = 0; i < NUM_AUX; i++) begin
            if (hit(bus_addr, A_AUX0 + i)) begin
               bus_rdata = {15'd0, aux_mask_q[i] | ~sw_en, 8'd0, aux_vec_q[i]};
            end
         end
      end
   end

   logic unused_wdata;
   assign unused_wdata = ^bus_wdata;

   // ---------------- assertions ----------------
   AST_RESET_MASKED: assert property (@(posedge clk)
      $rose(rst_n) |-> (tmr_mask_q && !sw_en)) else $error("reset state wrong"); // R1
   AST_TMR_MASK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !sw_en |=> tmr_mask_q) else $error("timer mask cleared while disabled"); // R2
   AST_NO_MASKED_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      (expire && tmr_mask_eff && !irq_pend) |=> !irq_pend) else $error("masked expiry delivered"); // R7
   AST_PEND_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_pend && !irq_ack) |=> (irq_pend && $stable(irq_vec)) || $past(expire)) else $error("pending dropped"); // R8
   AST_CUR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      cur <= init_q) else $error("count above initial value"); // R4
endmodule

// File: tb/lic_timer_tb.sv
module lic_timer_tb;
   localparam int CLK_PERIOD = 10;
   localparam int A_SVR = 0, A_TMR = 1, A_DIV = 2, A_INIT = 3, A_CUR = 4, A_AUX0 = 5;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq_ack = 1'b0;
   logic        irq_pend;
   logic [7:0]  irq_vec;
   logic        msg_valid = 1'b0;
   logic [1:0]  msg_type = '0;
   logic [7:0]  msg_vec = '0;
   logic        core_init, core_nmi, core_smi, core_sipi;
   logic [7:0]  core_sipi_vec;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   lic_timer u_dut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_ack(irq_ack),
      .irq_pend(irq_pend), .irq_vec(irq_vec), .msg_valid(msg_valid),
      .msg_type(msg_type), .msg_vec(msg_vec), .core_init(core_init),
      .core_nmi(core_nmi), .core_smi(core_smi), .core_sipi(core_sipi),
      .core_sipi_vec(core_sipi_vec)
   );

   function automatic int exp_cycles(input int n, input int code);
      return n << code;
   endfunction

   function automatic logic [31:0] exp_entry(input logic [7:0] v, input bit mask, input bit mode);
      return {14'd0, mode, mask, 8'd0, v};
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input int a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = 4'(a); bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input int a, output logic [31:0] d);
      bus_addr = 4'(a);
      #1;
      d = bus_rdata;
   endtask

   task automatic ack();
      irq_ack = 1'b1;
      @(negedge clk);
      irq_ack = 1'b0;
   endtask

   task automatic oneshot_run(input int n, input int code, input logic [7:0] v, input string req);
      logic [31:0] d;
      wr(A_SVR, 32'h1FF);
      wr(A_TMR, exp_entry(v, 1'b0, 1'b0));
      wr(A_DIV, 32'(code));
      wr(A_INIT, 32'(n));
      rd(A_CUR, d); chk({req, " R4 load"}, d, 32'(n));
      repeat (exp_cycles(n, code) - 1) @(negedge clk);
      chk({req, " R5 early"}, 32'(irq_pend), 32'd0);
      @(negedge clk);
      chk({req, " R5 edge"}, 32'(irq_pend), 32'd1);
      chk({req, " R5 vec"}, 32'(irq_vec), 32'(v));
      repeat (3) @(negedge clk);
      rd(A_CUR, d); chk({req, " R5 cur zero"}, d, 32'd0);
      ack();
      chk({req, " R8 ack clears"}, 32'(irq_pend), 32'd0);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin : main
      logic [31:0] d;
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(A_SVR, d); chk("R1 svr", d, 32'h0000_00FF);
      rd(A_TMR, d); chk("R1 timer entry", d, 32'h0001_0000);
      rd(A_CUR, d); chk("R1 cur", d, 32'd0);
      chk("R1 irq", 32'(irq_pend), 32'd0);

      // R2 masks stuck while disabled
      wr(A_TMR, 32'h0000_0050);
      rd(A_TMR, d); chk("R2 timer mask stuck", d, 32'h0001_0050);
      wr(A_AUX0 + 1, 32'h0000_0033);
      rd(A_AUX0 + 1, d); chk("R2 aux mask stuck", d, 32'h0001_0033);

      // R7 expiry while disabled delivers nothing
      wr(A_DIV, 32'd0);
      wr(A_INIT, 32'd5);
      repeat (10) @(negedge clk);
      chk("R7 disabled expiry", 32'(irq_pend), 32'd0);
      rd(A_CUR, d); chk("R7 count expired", d, 32'd0);

      // R10 system messages while disabled
      for (int t = 0; t < 4; t++) begin
         @(negedge clk);
         msg_valid = 1'b1; msg_type = 2'(t); msg_vec = 8'(8'h90 + t);
         @(negedge clk);
         msg_valid = 1'b0;
         chk("R10 pulse", {28'd0, core_sipi, core_smi, core_nmi, core_init}, 32'(1 << t));
         if (t == 3) chk("R10 sipi vec", 32'(core_sipi_vec), 32'h93);
         @(negedge clk);
         chk("R10 one cycle", {28'd0, core_sipi, core_smi, core_nmi, core_init}, 32'd0);
      end

      // R3 disable forces masks, stays after re-enable
      wr(A_SVR, 32'h1FF);
      wr(A_TMR, 32'h0000_0050);
      wr(A_AUX0, 32'h0000_0044);
      rd(A_TMR, d); chk("R3 unmasked when enabled", d, 32'h0000_0050);
      wr(A_SVR, 32'h0FF);
      rd(A_TMR, d); chk("R3 forced timer", d, 32'h0001_0050);
      rd(A_AUX0, d); chk("R3 forced aux", d, 32'h0001_0044);
      wr(A_SVR, 32'h1FF);
      rd(A_TMR, d); chk("R3 still masked", d, 32'h0001_0050);

      // R7 masked while enabled
      wr(A_INIT, 32'd4);
      repeat (8) @(negedge clk);
      chk("R7 masked expiry", 32'(irq_pend), 32'd0);

      // R4/R5 directed: divide by 16 and by 128
      oneshot_run(3, 4, 8'h50, "div16");
      begin
         wr(A_DIV, 32'd7);
         wr(A_INIT, 32'd2);
         repeat (128) @(negedge clk);
         rd(A_CUR, d); chk("R4 div128 step", d, 32'd1);
         repeat (127) @(negedge clk);
         chk("R5 div128 early", 32'(irq_pend), 32'd0);
         @(negedge clk);
         chk("R5 div128 edge", 32'(irq_pend), 32'd1);
         ack();
      end

      // constrained random one-shot runs
      for (int i = 0; i < 10; i++) begin
         oneshot_run(int'($urandom_range(1, 12)), int'($urandom_range(0, 3)),
                     8'($urandom_range(16, 255)), "rand");
      end

      // R8 pending held across disable
      wr(A_SVR, 32'h1FF);
      wr(A_TMR, exp_entry(8'h61, 1'b0, 1'b0));
      wr(A_DIV, 32'd0);
      wr(A_INIT, 32'd2);
      repeat (2) @(negedge clk);
      chk("R8 set", 32'(irq_pend), 32'd1);
      wr(A_SVR, 32'h0FF);
      repeat (5) @(negedge clk);
      chk("R8 held disabled", 32'(irq_pend), 32'd1);
      chk("R8 vec held", 32'(irq_vec), 32'h61);
      ack();
      chk("R8 ack", 32'(irq_pend), 32'd0);

      // R6 periodic with ack/expiry collision (R8)
      wr(A_SVR, 32'h1FF);
      wr(A_TMR, exp_entry(8'h72, 1'b0, 1'b1));
      wr(A_INIT, 32'd3);
      repeat (3) @(negedge clk);
      chk("R6 first", 32'(irq_pend), 32'd1);
      repeat (2) @(negedge clk);
      ack();
      chk("R8 collision set wins", 32'(irq_pend), 32'd1);
      ack();
      chk("R6 cleared between", 32'(irq_pend), 32'd0);
      repeat (2) @(negedge clk);
      chk("R6 third expiry", 32'(irq_pend), 32'd1);
      ack();

      // R9 stop by writing zero mid-count
      wr(A_INIT, 32'd10);
      repeat (3) @(negedge clk);
      wr(A_INIT, 32'd0);
      repeat (20) @(negedge clk);
      chk("R9 no irq", 32'(irq_pend), 32'd0);
      rd(A_CUR, d); chk("R9 cur zero", d, 32'd0);

      // R11 read-back of divide and initial count
      wr(A_DIV, 32'd5);
      rd(A_DIV, d); chk("R11 divide", d, 32'd5);
      rd(A_INIT, d); chk("R11 init", d, 32'd0);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule